// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash device. After software or a sequencer has sent a program or erase command, the poller repeatedly reads a status byte from the address being written. It decides from those reads whether the operation finished cleanly or failed. Each status read goes out over a simple request/valid read port. The read data may return one to four cycles after the request.

The decision rests on two bits of the returned byte. The poller compares the completion flag (bit 7) with bit 7 of the data byte that was written. A match means the operation has finished. When the flag does not match, the poller looks at the error flag (bit 5). If bit 5 is clear, it keeps polling. If bit 5 is set, it performs exactly one more read and checks bit 7 again. Only a mismatch on that confirming read is a failure.

A programmable ceiling on the number of reads stops a device that never settles. When the ceiling is hit, the poller reports a separate timeout failure. Every failure raises a one-cycle request for the external sequencer to issue the flash reset command.

Top module: `flash_poll_checker`

## Requirements
- R1: After a synchronous reset, `busy`, `rd_req`, `done`, `pass`, `fail`, `timeout` and `reset_req` are all 0.
- R2: A `start` pulse seen while `busy` is 0 begins a check. It latches bit 7 of `exp_data` and the `poll_addr` value, and `busy` rises on the next cycle. A `start` pulse seen while `busy` is 1 is ignored: the running check keeps its latched data and address, and its outcome is unchanged.
- R3: Every status read drives `rd_addr` equal to the latched address. `rd_req` stays high, with `rd_addr` stable, until a cycle in which `rd_valid` is 1. That cycle completes exactly one read. Read latencies of 1 to 4 cycles are supported.
- R4: If bit 7 of a returned byte equals the latched expected bit, the check ends with `pass`=1 and `fail`=0. This holds whatever the value of bit 5.
- R5: If bit 7 mismatches and bit 5 is 0, and the check is not in its confirming read, the poller issues another read.
- R6: If bit 7 mismatches and bit 5 is 1, the poller issues exactly one confirming read. A bit 7 match on that read ends the check with `pass`=1.
- R7: A bit 7 mismatch on the confirming read ends the check with `fail`=1 and `timeout`=0, and `reset_req` is pulsed.
- R8: `done` is high for exactly one cycle per check. `reset_req` is high only in a cycle where both `done` and `fail` are high.
- R9: When `max_polls` is nonzero and that many reads have completed without a pass or a confirmed failure, the check ends with `fail`=1, `timeout`=1 and a `reset_req` pulse. A `max_polls` of 0 means there is no limit.
- R10: `pass`, `fail` and `timeout` hold their values after `done` until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check (honoured only when idle) |
| exp_data | input | 8 | Data byte that was written; bit 7 is used |
| poll_addr | input | AW | Address to poll |
| max_polls | input | CW | Read ceiling, 0 = unlimited |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Returned status byte |
| rd_valid | input | 1 | Read data valid, completes the pending read |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle end-of-check pulse |
| pass | output | 1 | Operation completed |
| fail | output | 1 | Operation failed |
| timeout | output | 1 | Failure caused by the read ceiling |
| reset_req | output | 1 | One-cycle request to issue the flash reset command |

## Verification
Assertions check the following on every cycle: that a read request and its address stay stable until `rd_valid`, that `done` is a single-cycle pulse carrying exactly one verdict, that `reset_req` and `timeout` occur only alongside a failure, that the read count never passes the ceiling, and that results and the latched address are frozen while idle or while a stray start arrives. The bench sweeps four read latencies, both expected-bit polarities, up to three plain mismatches followed by each ending (direct match, match with bit 5 set, confirmed match, confirmed failure), and five ceilings. Only these scenarios can show that the verdict, the timeout flag and the exact number of reads follow the bit 5 / bit 7 rules.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} fsm_t;
  typedef enum logic [1:0] {DEC_PASS, DEC_FAIL, DEC_CONFIRM, DEC_RETRY} dec_t;
endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge
  import fpoll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int FLAG_BIT = 7,
  parameter int ERR_BIT  = 5
) (
  input  logic [DW-1:0] data,
  input  logic          exp_flag,
  input  logic          confirm,
  output dec_t          dec
);
  always_comb begin
    if (data[FLAG_BIT] == exp_flag) dec = DEC_PASS;
    else if (confirm)               dec = DEC_FAIL;
    else if (data[ERR_BIT])         dec = DEC_CONFIRM;
    else                            dec = DEC_RETRY;
  end
endmodule

// File: rtl/fpoll_reader.sv
module fpoll_reader (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic rd_valid,
  output logic rd_req,
  output logic accept
);
  assign accept = rd_req & rd_valid;

  always_ff @(posedge clk) begin
    if (rst)         rd_req <= 1'b0;
    else if (issue)  rd_req <= 1'b1;
    else if (accept) rd_req <= 1'b0;
  end

  // R3: request held until data returns
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req);
  // R3: a new read is only issued once the previous one has completed
  p_issue_clear_r3: assert property (@(posedge clk) disable iff (rst)
    issue |-> !rd_req);
endmodule

// File: rtl/fpoll_limit.sv
module fpoll_limit #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] max_polls,
  output logic          last_poll
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last_poll = (max_polls != '0) && (cnt == max_polls - CW'(1));

  // R9: no read completes beyond the ceiling
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    inc && (max_polls != '0) |-> cnt < max_polls);
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
  import fpoll_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    exp_data,
  input  logic [AW-1:0] poll_addr,
  input  logic [CW-1:0] max_polls,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  input  logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout,
  output logic          reset_req
);
  fsm_t          state;
  logic          exp_q;
  logic          confirm;
  logic [AW-1:0] addr_q;
  logic          accept;
  logic          last_poll;
  logic          launch;
  dec_t          dec;

  assign launch  = (state == ST_IDLE) && start;
  assign busy    = (state != ST_IDLE);
  assign rd_addr = addr_q;

  fpoll_reader u_reader (
    .clk(clk), .rst(rst), .issue(state == ST_ISSUE),
    .rd_valid(rd_valid), .rd_req(rd_req), .accept(accept)
  );

  fpoll_limit #(.CW(CW)) u_limit (
    .clk(clk), .rst(rst), .clr(launch), .inc(accept),
    .max_polls(max_polls), .last_poll(last_poll)
  );

  fpoll_judge #(.DW(8), .FLAG_BIT(7), .ERR_BIT(5)) u_judge (
    .data(rd_data), .exp_flag(exp_q), .confirm(confirm), .dec(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      exp_q     <= 1'b0;
      confirm   <= 1'b0;
      addr_q    <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      timeout   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      done      <= 1'b0;
      reset_req <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          exp_q   <= exp_data[7];
          addr_q  <= poll_addr;
          confirm <= 1'b0;
          pass    <= 1'b0;
          fail    <= 1'b0;
          timeout <= 1'b0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (accept) begin
          if (dec == DEC_PASS) begin
            pass  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (dec == DEC_FAIL) begin
            fail      <= 1'b1;
            done      <= 1'b1;
            reset_req <= 1'b1;
            state     <= ST_IDLE;
          end else if (last_poll) begin
            fail      <= 1'b1;
            timeout   <= 1'b1;
            done      <= 1'b1;
            reset_req <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            if (dec == DEC_CONFIRM) confirm <= 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8, R7: reset request only alongside a failing done
  p_reset_req_fail_r8: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> done && fail);
  // R4: exactly one verdict at done
  p_one_verdict_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({pass, fail}));
  // R9: timeout is a kind of failure
  p_timeout_fail_r9: assert property (@(posedge clk) disable iff (rst)
    timeout |-> fail);
  // R2: start while busy leaves the latched address alone
  p_start_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(rd_addr));
  // R3: address steady while a read is pending
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> $stable(rd_addr));
  // R10: results frozen while idle without start
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable({pass, fail, timeout}));
endmodule

// File: tb/sim_flash_poll_checker.sv
module sim_flash_poll_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  exp_data = '0;
  logic [15:0] poll_addr = '0;
  logic [7:0]  max_polls = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        rd_valid = 1'b0;
  logic        busy, done, pass, fail, timeout, reset_req;

  always #5 clk = ~clk;

  flash_poll_checker u0 (
    .clk(clk), .rst(rst), .start(start), .exp_data(exp_data),
    .poll_addr(poll_addr), .max_polls(max_polls), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .timeout(timeout), .reset_req(reset_req)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic [7:0]  scr [8];
  logic [15:0] want_addr = '0;
  logic        cur_e = 1'b0;
  int lat = 1;
  int ri = 0;
  int lcnt = 0;
  bit addr_bad = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // read responder: latency counted in cycles while rd_req is high
  initial forever begin
    @(negedge clk);
    if (rd_valid) begin
      rd_valid = 1'b0;
      ri++;
      lcnt = 0;
    end else if (rd_req) begin
      if (rd_addr !== want_addr) addr_bad = 1;
      lcnt++;
      if (lcnt >= lat) begin
        rd_valid = 1'b1;
        rd_data  = (ri < 8) ? scr[ri] : {~cur_e, 7'h11};
      end
    end
  end

  initial begin
    @(negedge clk);
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic scenario(input logic e, input int n, input int kind,
                          input int mx, input bit inject);
    logic ep, ef, et, cf, fin;
    int ereads, w;
    logic [7:0] b;
    for (int i = 0; i < 8; i++) scr[i] = {~e, 2'b00, 5'(i + 2)};
    case (kind)
      0: scr[n] = {e, 7'h05};
      1: begin scr[n] = {~e, 2'b01, 5'h0A}; scr[n+1] = {e, 7'h2C}; end
      2: begin scr[n] = {~e, 2'b01, 5'h0B}; scr[n+1] = {~e, 7'h3C}; end
      default: scr[n] = {e, 2'b01, 5'h1F};
    endcase
    // reference outcome from the bit rules
    ep = 0; ef = 0; et = 0; cf = 0; fin = 0; ereads = 0;
    for (int i = 0; i < 8; i++) begin
      if (!fin) begin
        b = scr[i];
        ereads = i + 1;
        if (b[7] == e) begin ep = 1; fin = 1; end
        else if (cf) begin ef = 1; fin = 1; end
        else begin
          if (b[5]) cf = 1;
          if (mx != 0 && ereads == mx) begin ef = 1; et = 1; fin = 1; end
        end
      end
    end
    cur_e = e;
    want_addr = 16'h4000 + 16'(n * 16 + kind * 4 + mx);
    ri = 0; lcnt = 0; addr_bad = 0;
    @(negedge clk);
    start = 1; exp_data = {e, 7'h5A}; poll_addr = want_addr; max_polls = 8'(mx);
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", busy, 1);
    chk("R10 results cleared at start", {pass, fail, timeout}, 0);
    if (inject) begin
      w = 0;
      while (!rd_req && w < 20) begin @(negedge clk); w++; end
      start = 1; exp_data = {~e, 7'h00}; poll_addr = ~want_addr;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (!done && w < 400) begin @(negedge clk); w++; end
    chk("R8 done seen", done, 1);
    chk("R4 R6 pass", pass, ep);
    chk("R7 fail", fail, ef);
    chk("R9 timeout", timeout, et);
    chk("R7 R9 reset_req", reset_req, ef);
    @(negedge clk);
    chk("R8 done single cycle", {done, reset_req}, 0);
    chk("R10 result held", {pass, fail, timeout}, {ep, ef, et});
    chk("R5 R6 read count", ri, ereads);
    chk("R3 read address", addr_bad, 0);
    chk("R2 idle after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset outputs", {busy, rd_req, done, pass, fail, timeout, reset_req}, 0);
    for (int l = 1; l <= 4; l++) begin
      lat = l;
      for (int e = 0; e < 2; e++)
        for (int n = 0; n < 4; n++)
          for (int k = 0; k < 4; k++)
            for (int m = 0; m < 5; m++) begin
              int mxv;
              mxv = (m == 4) ? 5 : m;
              scenario(e[0], n, k, mxv, (n == 1 && m == 0));
            end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule